// File: doc/BRIEF.md
# Flash Read-Mode Command Controller

This block is the command front end of a parallel NOR flash model. It decides what a read cycle on the 16-bit data bus returns. Bus writes carry command bytes that select a read mode. The selected mode stays in force until another recognised command is written. There are three read modes. Array mode passes through data from the external storage array. Status mode returns an externally supplied 8-bit status byte. Identification mode decodes the read address into the manufacturer code, the device code, the lock state of one block, or the one-time protection words.

The block samples the active-low bus strobes on a system clock. It captures a command on the sampled rising edge of the write strobe while the chip is selected. Read data is registered. It appears one clock after a sampled read cycle, where chip select and output enable are both low, together with a valid flag. The upper address bits go out as a block index, so that surrounding logic can return that block's lock flags.

Top module: `flash_rdmode_ctrl`

## Requirements
- R1: After reset the mode is array read, and `rdata_o` and `rd_vld_o` are zero.
- R2: In array mode, a read returns `array_data_i`.
- R3: A write with low byte 0x90 selects identification mode. Identification mode holds for every later read until another recognised command arrives. The upper data byte of a command is ignored.
- R4: A write with low byte 0xFF returns the block to array mode.
- R5: A write with low byte 0x70 selects status mode. Reads then return `{8'h00, status_i}`.
- R6: In identification mode, the low address field (`addr_i[LOW_W-1:0]`, LOW_W=12) selects the returned value. Field 0x000 returns 0x0089. Field 0x001 returns the DEV_CODE parameter.
- R7: In identification mode, low field 0x002 returns the lock state in bits [1:0]. The encoding is 00 for unlocked, 01 for locked, and 11 for locked-down (`lock_down_i` high). Bits [15:2] read as zero.
- R8: In identification mode, low field 0x080 returns `prot_lock_i`. Low fields 0x081 to 0x088 return protection words 0 to 7 of `prot_data_i`, where word k is bits [16k+15:16k].
- R9: In identification mode, any other low field returns 0x0000.
- R10: A command is taken only on a sampled rising edge of `we_ni` while `ce_ni` is low. A write with `ce_ni` high has no effect. So does any unrecognised code, for example 0x42.
- R11: `rd_vld_o` is high exactly one clock after a sampled read cycle (`ce_ni`=0, `oe_ni`=0). Otherwise `rd_vld_o` and `rdata_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write strobe, active low |
| addr_i | input | 20 | Read/write address |
| data_i | input | 16 | Write data (command byte in [7:0]) |
| array_data_i | input | 16 | Array read data from storage |
| status_i | input | 8 | Status byte |
| locked_i | input | 1 | Selected block is locked |
| lock_down_i | input | 1 | Selected block is locked-down |
| prot_lock_i | input | 16 | Protection lock word |
| prot_data_i | input | 128 | Eight protection words, packed |
| blk_sel_o | output | 8 | Block index taken from the upper address bits |
| rdata_o | output | 16 | Registered read data |
| rd_vld_o | output | 1 | Read data valid |

## Verification
The assertions check the following on every cycle:
- the one-cycle timing of the valid flag, and the zeroed bus outside reads;
- the zero upper byte in status mode;
- that the lock field never returns the illegal 10 code;
- that the mode holds unless a command strobe occurs;
- that 0xFF always lands in array mode.

Only the bench scenarios can show the values returned at each decoded offset, the mode changes made by each command code, and that unselected or unknown writes are ignored.

// File: rtl/flash_rdmode_pkg.sv
package flash_rdmode_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_IDENT  = 2'd1,
    MODE_STATUS = 2'd2
  } rd_mode_e;

  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_STATUS = 8'h70;
  localparam logic [15:0] MFR_CODE  = 16'h0089;
endpackage

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
  import flash_rdmode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_ni,
  input  logic       we_ni,
  input  logic [7:0] cmd_i,
  output rd_mode_e   mode_o,
  output logic       cmd_stb_o
);
  logic     we_q;
  rd_mode_e mode_q;

  // rising edge of the write strobe while selected
  assign cmd_stb_o = !we_q && we_ni && !ce_ni;
  assign mode_o    = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b1;
      mode_q <= MODE_ARRAY;
    end else begin
      we_q <= we_ni;
      if (cmd_stb_o) begin
        unique case (cmd_i)
          CMD_IDENT:  mode_q <= MODE_IDENT;
          CMD_ARRAY:  mode_q <= MODE_ARRAY;
          CMD_STATUS: mode_q <= MODE_STATUS;
          default:    mode_q <= mode_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_ident_dec.sv
module flash_ident_dec
  import flash_rdmode_pkg::*;
#(
  parameter int          LOW_W    = 12,
  parameter int          DATA_W   = 16,
  parameter int          PR_WORDS = 8,
  parameter logic [15:0] DEV_CODE = 16'h88C2
) (
  input  logic [LOW_W-1:0]         low_i,
  input  logic                     locked_i,
  input  logic                     lock_down_i,
  input  logic [DATA_W-1:0]        prot_lock_i,
  input  logic [PR_WORDS*DATA_W-1:0] prot_data_i,
  output logic [DATA_W-1:0]        data_o
);
  localparam logic [LOW_W-1:0] OFS_MFR  = LOW_W'(0);
  localparam logic [LOW_W-1:0] OFS_DEV  = LOW_W'(1);
  localparam logic [LOW_W-1:0] OFS_LOCK = LOW_W'(2);
  localparam logic [LOW_W-1:0] OFS_PRL  = LOW_W'('h80);

  always_comb begin
    data_o = '0;
    if (low_i == OFS_MFR)       data_o = DATA_W'(MFR_CODE);
    else if (low_i == OFS_DEV)  data_o = DATA_W'(DEV_CODE);
    else if (low_i == OFS_LOCK) data_o = DATA_W'({lock_down_i, locked_i | lock_down_i});
    else if (low_i == OFS_PRL)  data_o = prot_lock_i;
    else begin
      for (int i = 0; i < PR_WORDS; i++) begin
        if (low_i == OFS_PRL + LOW_W'(i + 1))
          data_o = prot_data_i[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
  import flash_rdmode_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  rd_mode_e          mode_i,
  input  logic [DATA_W-1:0] array_i,
  input  logic [DATA_W-1:0] ident_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_vld_o
);
  logic [DATA_W-1:0] sel_d;

  always_comb begin
    unique case (mode_i)
      MODE_IDENT:  sel_d = ident_i;
      MODE_STATUS: sel_d = DATA_W'(status_i);
      default:     sel_d = array_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rd_vld_o <= 1'b0;
    end else begin
      rd_vld_o <= rd_i;
      rdata_o  <= rd_i ? sel_d : '0;
    end
  end
endmodule

// File: rtl/flash_rdmode_ctrl.sv
module flash_rdmode_ctrl
  import flash_rdmode_pkg::*;
#(
  parameter int          ADDR_W   = 20,
  parameter int          LOW_W    = 12,
  parameter int          DATA_W   = 16,
  parameter int          STAT_W   = 8,
  parameter int          PR_WORDS = 8,
  parameter logic [15:0] DEV_CODE = 16'h88C2,
  localparam int         BLK_W    = ADDR_W - LOW_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ce_ni,
  input  logic                       oe_ni,
  input  logic                       we_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          data_i,
  input  logic [DATA_W-1:0]          array_data_i,
  input  logic [STAT_W-1:0]          status_i,
  input  logic                       locked_i,
  input  logic                       lock_down_i,
  input  logic [DATA_W-1:0]          prot_lock_i,
  input  logic [PR_WORDS*DATA_W-1:0] prot_data_i,
  output logic [BLK_W-1:0]           blk_sel_o,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       rd_vld_o
);
  rd_mode_e          mode;
  logic              cmd_stb;
  logic [DATA_W-1:0] ident_data;
  logic              unused_cmd_hi;

  assign unused_cmd_hi = ^data_i[DATA_W-1:8];
  assign blk_sel_o     = addr_i[ADDR_W-1:LOW_W];

  flash_cmd_dec u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_ni     (ce_ni),
    .we_ni     (we_ni),
    .cmd_i     (data_i[7:0]),
    .mode_o    (mode),
    .cmd_stb_o (cmd_stb)
  );

  flash_ident_dec #(
    .LOW_W(LOW_W), .DATA_W(DATA_W), .PR_WORDS(PR_WORDS), .DEV_CODE(DEV_CODE)
  ) u_ident (
    .low_i       (addr_i[LOW_W-1:0]),
    .locked_i    (locked_i),
    .lock_down_i (lock_down_i),
    .prot_lock_i (prot_lock_i),
    .prot_data_i (prot_data_i),
    .data_o      (ident_data)
  );

  flash_rd_mux #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (!ce_ni && !oe_ni),
    .mode_i   (mode),
    .array_i  (array_data_i),
    .ident_i  (ident_data),
    .status_i (status_i),
    .rdata_o  (rdata_o),
    .rd_vld_o (rd_vld_o)
  );
endmodule

// File: rtl/flash_rdmode_ctrl_chk.sv
module flash_rdmode_ctrl_chk
  import flash_rdmode_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LOW_W  = 12,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        cmd,
  input logic              cmd_stb,
  input rd_mode_e          mode,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rd_vld_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  assert_vld_timing_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (rd_vld_o == $past(!ce_ni && !oe_ni)));

  assert_idle_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_vld_o |-> (rdata_o == '0));

  assert_status_hi_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && rd_vld_o && $past(mode == MODE_STATUS)) |-> (rdata_o[DATA_W-1:8] == '0));

  assert_lock_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && rd_vld_o && $past(mode == MODE_IDENT && addr_i[LOW_W-1:0] == LOW_W'(2)))
      |-> (rdata_o[DATA_W-1:2] == '0 && rdata_o[1:0] != 2'b10));

  assert_mode_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_stb |=> $stable(mode));

  assert_array_cmd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_stb && cmd == CMD_ARRAY) |=> (mode == MODE_ARRAY));
endmodule

bind flash_rdmode_ctrl flash_rdmode_ctrl_chk #(
  .ADDR_W(ADDR_W), .LOW_W(LOW_W), .DATA_W(DATA_W)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ce_ni    (ce_ni),
  .oe_ni    (oe_ni),
  .addr_i   (addr_i),
  .cmd      (data_i[7:0]),
  .cmd_stb  (cmd_stb),
  .mode     (mode),
  .rdata_o  (rdata_o),
  .rd_vld_o (rd_vld_o)
);

// File: tb/flash_rdmode_ctrl_tb.sv
module flash_rdmode_ctrl_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [19:0]  addr = '0;
  logic [15:0]  wdata = '0;
  logic [15:0]  array_data;
  logic [7:0]   status = 8'hA6;
  logic         locked = 1'b0, lock_down = 1'b0;
  logic [15:0]  prot_lock = 16'hFFFD;
  logic [127:0] prot_data;
  logic [7:0]   blk_sel;
  logic [15:0]  rdata;
  logic         rd_vld;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  assign array_data = addr[15:0] ^ 16'h5A3C;
  for (genvar k = 0; k < 8; k++) begin : g_pr
    assign prot_data[k*16 +: 16] = 16'h1000 + 16'(k * 'h111);
  end

  flash_rdmode_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .data_i(wdata), .array_data_i(array_data), .status_i(status),
    .locked_i(locked), .lock_down_i(lock_down), .prot_lock_i(prot_lock),
    .prot_data_i(prot_data), .blk_sel_o(blk_sel), .rdata_o(rdata), .rd_vld_o(rd_vld)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cmd(logic [15:0] d, logic sel);
    @(negedge clk); ce_n = !sel; we_n = 1'b0; wdata = d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic rd(logic [19:0] a, logic [15:0] exp, string req);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n && rd_vld) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R11 actual=unexpected_read expected=none");
        end else begin
          string t = tag_q.pop_front();
          check(t, rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", rdata, 16'h0000);
    check("R1", {15'd0, rd_vld}, 16'h0000);
    rst_n = 1'b1;
    rd(20'h00123, 20'h00123 ^ 16'h5A3C, "R1");
    rd(20'h0F00F, 16'hF00F ^ 16'h5A3C, "R2");
    @(negedge clk); check("R11", {15'd0, rd_vld}, 16'h0000);
    check("R11", rdata, 16'h0000);
    wr_cmd(16'h0090, 1'b0);  // R10 unselected write ignored
    rd(20'h00000, 16'h5A3C, "R10");
    wr_cmd(16'h7F90, 1'b1);  // upper byte ignored
    rd(20'h00000, 16'h0089, "R6");
    rd(20'h35001, 16'h88C2, "R6");
    rd(20'h00000, 16'h0089, "R3");
    locked = 1'b0; lock_down = 1'b0; rd(20'h42002, 16'h0000, "R7");
    locked = 1'b1; rd(20'h42002, 16'h0001, "R7");
    lock_down = 1'b1; rd(20'h42002, 16'h0003, "R7");
    locked = 1'b0; rd(20'h42002, 16'h0003, "R7");
    lock_down = 1'b0;
    rd(20'h00080, 16'hFFFD, "R8");
    for (int k = 0; k < 8; k++)
      rd(20'h00081 + 20'(k), 16'h1000 + 16'(k * 'h111), "R8");
    rd(20'h00003, 16'h0000, "R9");
    rd(20'h00089, 16'h0000, "R9");
    rd(20'h0007F, 16'h0000, "R9");
    wr_cmd(16'h0042, 1'b1);  // unknown code
    rd(20'h00001, 16'h88C2, "R10");
    wr_cmd(16'h0070, 1'b1);
    rd(20'h00000, 16'h00A6, "R5");
    status = 8'h80; rd(20'h00002, 16'h0080, "R5");
    wr_cmd(16'h0090, 1'b1);
    wr_cmd(16'h00FF, 1'b1);
    rd(20'h00000, 16'h5A3C, "R4");
    rd(20'h00080, 16'h00BC ^ 16'h5A00, "R4");
    @(negedge clk); check("R2", {8'd0, blk_sel}, 16'h0000);
    repeat (3) @(negedge clk);
    check("R11", 16'(exp_q.size()), 16'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule